// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Bank

This block generates pulse-width modulated outputs on several independent channels (four by default). Each channel is programmed through a small word-addressed register port. The port has a write strobe, a read strobe, a byte address and 32-bit data. Each channel has three registers: a period, an on-time (duty) and a control word. The control word picks a prescale ratio for the channel's tick and the polarity of its output. Every channel counts ticks of a shared one-microsecond tick-enable pulse after its own prescaler, so the whole bank runs on a single system clock.

Programmed values are not applied directly. Duty and control writes wait in staging registers. A period write arms a hand-over, which the channel performs at the end of the period it is running, so the output never shows a mix of old and new settings. A channel that is idle starts at its next prescaled tick. A period of zero stops the channel once the current period has finished, and the pin is then held low.

Top module: `pwm_bank`

## Requirements
- R1: A synchronous reset drives every output low, stops every channel and clears all registers, so that every register reads 0.
- R2: For channel n, the registers sit at these byte addresses: period at 0x400+4n, duty at 0x420+4n and control at 0x440+4n. In the control word, bits [1:0] hold the prescale select and bit 5 holds the polarity; its other bits read 0. A read returns the last programmed value on `rdata` in the cycle after `rd_en`. Unmapped or misaligned addresses read 0, and writes to them are ignored.
- R3: A channel advances one count per 2^sel pulses of `tick_en`, where sel is the prescale select (ratios 1, 2, 4, 8). While `tick_en` is low, every output holds its level.
- R4: One period lasts `period` prescaled ticks. The output is active while the count within the period is below `duty`. A duty equal to or above the period gives a constant active level.
- R5: With control bit 5 set, the active level is low and the inactive level is high.
- R6: Duty and control writes that are not followed by a period write never change the output.
- R7: After a period write, the running period completes with the old settings. The staged period, duty and control then all apply together from the next period.
- R8: A period of zero takes effect at the end of the running period. From then on the output is low, whatever the polarity.
- R9: When an idle channel receives a nonzero period write, it starts its first period on the next prescaled tick, without waiting for any boundary.
- R10: Channels are independent. Programming one channel does not alter the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timebase pulse, one cycle wide, nominally 1 MHz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (12) | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pwm_o | output | NUM_CH (4) | One PWM output per channel |

## Verification
The bench targets the hand-over point. It writes a new period just after a pulse has begun and measures the length of that pulse and of the next one. A design that applied settings at once would stretch the running pulse, and one that ignored the period strobe would never change it. It stops a channel mid-pulse and checks that the pulse still completes and that the pin then stays low, including on an inverted channel. A design that forgot the inversion when idle would leave the pin high. It also covers these cases:
- a start from idle, where a design waiting for a boundary would show a late first pulse;
- a duty at or above the period;
- a period of one;
- each prescale ratio;
- frozen ticks;
- staged writes that must stay invisible.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // prescale select width; ratio = 2**sel
   localparam int PRESEL_W    = 2;
   // control word: polarity position
   localparam int CTL_POL_BIT = 5;

   typedef enum logic [1:0] {
      REG_NONE = 2'd0,
      REG_PER  = 2'd1,
      REG_DUT  = 2'd2,
      REG_CTL  = 2'd3
   } reg_kind_e;

   typedef struct packed {
      logic                pol;
      logic [PRESEL_W-1:0] div;
   } chan_cfg_t;

endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ADDR_W   = 12,
   parameter int IDX_W    = 2,
   parameter int PER_BASE = 'h400,
   parameter int DUT_BASE = 'h420,
   parameter int CTL_BASE = 'h440
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind_o,
   output logic [IDX_W-1:0]  idx_o
);

   always_comb begin
      kind_o = REG_NONE;
      idx_o  = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (addr == ADDR_W'(PER_BASE + 4 * k)) begin
            kind_o = REG_PER;
            idx_o  = IDX_W'(k);
         end
         if (addr == ADDR_W'(DUT_BASE + 4 * k)) begin
            kind_o = REG_DUT;
            idx_o  = IDX_W'(k);
         end
         if (addr == ADDR_W'(CTL_BASE + 4 * k)) begin
            kind_o = REG_CTL;
            idx_o  = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
   import pwm_bank_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic                tick_en,
   input  logic [PRESEL_W-1:0] sel,
   output logic                tick_o
);

   localparam int PC_W = (1 << PRESEL_W) - 1;

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] limit;

   assign limit  = PC_W'((1 << sel) - 1);
   assign tick_o = tick_en && (pc_q >= limit);

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else if (tick_en)
         pc_q <= tick_o ? '0 : pc_q + 1'b1;
   end

   // R3: a prescaled tick only ever comes from a timebase pulse
   p_tick_gated_r3 : assert property (@(posedge clk) disable iff (rst)
      tick_o |-> tick_en);

   // R3: ratio 1 passes every timebase pulse
   p_div_one_r3 : assert property (@(posedge clk) disable iff (rst)
      (tick_en && sel == '0) |-> tick_o);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             wr_per,
   input  logic             wr_dut,
   input  logic             wr_ctl,
   input  logic [CNT_W-1:0] wr_cnt,
   input  chan_cfg_t        wr_cfg,
   output logic [CNT_W-1:0] prog_per_o,
   output logic [CNT_W-1:0] prog_dut_o,
   output chan_cfg_t        prog_cfg_o,
   output logic             pwm_o
);

   logic [CNT_W-1:0] prog_per_q, prog_dut_q;
   chan_cfg_t        prog_cfg_q;
   logic [CNT_W-1:0] act_per_q, act_dut_q;
   chan_cfg_t        act_cfg_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             ch_tick, running, at_end, load_now, on_phase;

   pwm_prescale u_pre (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .sel     (act_cfg_q.div),
      .tick_o  (ch_tick)
   );

   assign running  = (act_per_q != '0);
   assign at_end   = running && (cnt_q == act_per_q - 1'b1);
   assign load_now = pend_q && (!running || at_end);
   assign on_phase = (cnt_q < act_dut_q);
   assign pwm_o    = running && (on_phase ^ act_cfg_q.pol);

   always_ff @(posedge clk) begin
      if (rst) begin
         prog_per_q <= '0;
         prog_dut_q <= '0;
         prog_cfg_q <= '0;
         act_per_q  <= '0;
         act_dut_q  <= '0;
         act_cfg_q  <= '0;
         cnt_q      <= '0;
         pend_q     <= 1'b0;
      end else begin
         if (ch_tick) begin
            if (load_now) begin
               act_per_q <= prog_per_q;
               act_dut_q <= prog_dut_q;
               act_cfg_q <= prog_cfg_q;
               cnt_q     <= '0;
               pend_q    <= 1'b0;
            end else if (at_end) begin
               cnt_q <= '0;
            end else if (running) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (wr_dut) prog_dut_q <= wr_cnt;
         if (wr_ctl) prog_cfg_q <= wr_cfg;
         if (wr_per) begin
            prog_per_q <= wr_cnt;
            pend_q     <= 1'b1;
         end
      end
   end

   assign prog_per_o = prog_per_q;
   assign prog_dut_o = prog_dut_q;
   assign prog_cfg_o = prog_cfg_q;

   // R6: with nothing armed, the applied settings never move
   p_active_frozen_r6 : assert property (@(posedge clk) disable iff (rst)
      !pend_q |=> ($stable(act_per_q) && $stable(act_dut_q) && $stable(act_cfg_q)));

   // R7: a period write always arms the hand-over
   p_period_arms_r7 : assert property (@(posedge clk) disable iff (rst)
      wr_per |=> pend_q);

   // R4: the in-period count stays inside the period
   p_count_bound_r4 : assert property (@(posedge clk) disable iff (rst)
      running |-> (cnt_q < act_per_q));

   // R4: full duty on a normal-polarity channel keeps the pin high
   p_full_duty_r4 : assert property (@(posedge clk) disable iff (rst)
      (running && act_dut_q >= act_per_q && !act_cfg_q.pol) |-> pwm_o);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 12,
   parameter int PER_BASE = 'h400,
   parameter int DUT_BASE = 'h420,
   parameter int CTL_BASE = 'h440
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [NUM_CH-1:0] pwm_o
);

   localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int SPAN   = 4 * NUM_CH;
   localparam int WR_N   = 3 * NUM_CH;

   // elaboration-time parameter checks
   if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_nch
      $error("pwm_bank: NUM_CH must be 2..8");
   end
   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
      $error("pwm_bank: CNT_W must be 2..24");
   end
   if ((PER_BASE % 4) != 0 || (DUT_BASE % 4) != 0 || (CTL_BASE % 4) != 0) begin : g_bad_align
      $error("pwm_bank: register bases must be word aligned");
   end
   if (PER_BASE + SPAN > DUT_BASE || DUT_BASE + SPAN > CTL_BASE) begin : g_bad_overlap
      $error("pwm_bank: register windows overlap");
   end
   if (CTL_BASE + SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("pwm_bank: register windows exceed ADDR_W");
   end

   reg_kind_e        dec_kind;
   logic [IDX_W-1:0] dec_idx;
   chan_cfg_t        wr_cfg;
   logic [WR_N-1:0]  wr_vec;
   logic [31:0]      rd_word, rdata_q;
   logic [CNT_W-1:0] prog_per [NUM_CH];
   logic [CNT_W-1:0] prog_dut [NUM_CH];
   chan_cfg_t        prog_cfg [NUM_CH];
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   pwm_bank_decode #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .PER_BASE (PER_BASE),
      .DUT_BASE (DUT_BASE),
      .CTL_BASE (CTL_BASE)
   ) u_dec (
      .addr   (addr),
      .kind_o (dec_kind),
      .idx_o  (dec_idx)
   );

   assign wr_cfg.pol = wdata[CTL_POL_BIT];
   assign wr_cfg.div = wdata[PRESEL_W-1:0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_here, s_per, s_dut, s_ctl;
      assign sel_here = wr_en && (dec_idx == IDX_W'(i));
      assign s_per    = sel_here && (dec_kind == REG_PER);
      assign s_dut    = sel_here && (dec_kind == REG_DUT);
      assign s_ctl    = sel_here && (dec_kind == REG_CTL);
      assign wr_vec[3*i +: 3] = {s_per, s_dut, s_ctl};

      pwm_chan #(.CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst        (rst),
         .tick_en    (tick_en),
         .wr_per     (s_per),
         .wr_dut     (s_dut),
         .wr_ctl     (s_ctl),
         .wr_cnt     (wdata[CNT_W-1:0]),
         .wr_cfg     (wr_cfg),
         .prog_per_o (prog_per[i]),
         .prog_dut_o (prog_dut[i]),
         .prog_cfg_o (prog_cfg[i]),
         .pwm_o      (pwm_o[i])
      );
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (dec_idx == IDX_W'(k)) begin
            case (dec_kind)
               REG_PER: rd_word = 32'(prog_per[k]);
               REG_DUT: rd_word = 32'(prog_dut[k]);
               REG_CTL: begin
                  rd_word[CTL_POL_BIT]    = prog_cfg[k].pol;
                  rd_word[PRESEL_W-1:0]   = prog_cfg[k].div;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         rdata_q <= '0;
      else if (rd_en)
         rdata_q <= rd_word;
   end

   assign rdata = rdata_q;

   // R2: at most one register strobe per write
   p_one_strobe_r2 : assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_vec));

   // R2: an unmapped read returns zero
   p_unmapped_zero_r2 : assert property (@(posedge clk) disable iff (rst)
      (rd_en && dec_kind == REG_NONE) |=> (rdata == 32'd0));

endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_en = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  pwm_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pwm_bank u_dut (
      .clk     (clk),
      .rst     (rst),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .pwm_o   (pwm_o)
   );

   // fields: period, duty, control, expected active-high samples per window
   localparam logic [55:0] VEC [9] = '{
      {16'd10, 16'd3,  8'h00, 16'd3},
      {16'd10, 16'd0,  8'h00, 16'd0},
      {16'd10, 16'd10, 8'h00, 16'd10},
      {16'd10, 16'd15, 8'h00, 16'd10},
      {16'd8,  16'd3,  8'h01, 16'd6},
      {16'd6,  16'd2,  8'h03, 16'd16},
      {16'd10, 16'd3,  8'h20, 16'd7},
      {16'd5,  16'd2,  8'h22, 16'd12},
      {16'd1,  16'd1,  8'h00, 16'd1}
   };

   function automatic logic [11:0] a_per(input int ch); return 12'(12'h400 + 4 * ch); endfunction
   function automatic logic [11:0] a_dut(input int ch); return 12'(12'h420 + 4 * ch); endfunction
   function automatic logic [11:0] a_ctl(input int ch); return 12'(12'h440 + 4 * ch); endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all tasks enter and leave at a falling edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic count_high(input int ch, input int len, output int n);
      n = 0;
      for (int c = 0; c < len; c++) begin
         @(negedge clk);
         if (pwm_o[ch]) n++;
      end
   endtask

   task automatic wait_rise(input int ch);
      logic prev;
      prev = pwm_o[ch];
      forever begin
         @(negedge clk);
         if (!prev && pwm_o[ch]) break;
         prev = pwm_o[ch];
      end
   endtask

   task automatic run_rest(input int ch, inout int n);
      while (pwm_o[ch]) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1..: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      int n;
      logic ref_lvl;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 outputs low in reset", int'(pwm_o), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 outputs low after reset", int'(pwm_o), 0);
      rd(a_per(0), d); chk("R1 period reads 0", int'(d), 0);
      rd(a_dut(3), d); chk("R1 duty reads 0", int'(d), 0);
      rd(a_ctl(3), d); chk("R1 control reads 0", int'(d), 0);

      // R4 R5 R3: table of waveforms, channel rotates
      for (int v = 0; v < 9; v++) begin
         int ch, per, win;
         ch  = v % 4;
         per = int'(VEC[v][55:40]);
         wr(a_ctl(ch), 32'(VEC[v][23:16]));
         wr(a_dut(ch), 32'(VEC[v][39:24]));
         wr(a_per(ch), 32'(per));
         repeat (150) @(negedge clk);
         win = per << VEC[v][17:16];
         count_high(ch, win, n);
         chk($sformatf("R4 R5 R3 vector %0d high count", v), n, int'(VEC[v][15:0]));
      end

      // R10: earlier channels keep their own waveform
      count_high(1, 48, n); chk("R10 ch1 unchanged", n, 16);
      count_high(3, 20, n); chk("R10 ch3 unchanged", n, 12);

      // R2 R6: staged writes visible on read, invisible on pin (ch2: 10,3,inverted)
      wr(a_ctl(2), 32'hFF);
      wr(a_dut(2), 32'h1234);
      rd(a_ctl(2), d); chk("R2 control readback", int'(d), 32'h23);
      rd(a_dut(2), d); chk("R2 duty readback", int'(d), 32'h1234);
      rd(a_per(2), d); chk("R2 period readback", int'(d), 10);
      rd(12'h460, d);  chk("R2 unmapped read", int'(d), 0);
      rd(12'h402, d);  chk("R2 misaligned read", int'(d), 0);
      repeat (60) @(negedge clk);
      count_high(2, 10, n); chk("R6 staged writes no effect", n, 7);

      // R7: hand-over only at end of running period (ch0)
      wr(a_ctl(0), 32'h0);
      wr(a_dut(0), 32'd5);
      wr(a_per(0), 32'd20);
      repeat (60) @(negedge clk);
      wr(a_dut(0), 32'd15);
      wait_rise(0);
      n = 1;
      wr(a_per(0), 32'd20);
      run_rest(0, n);
      chk("R7 running pulse keeps old duty", n, 5);
      wait_rise(0);
      n = 0;
      run_rest(0, n);
      chk("R7 next pulse uses new duty", n, 15);

      // R8: stop after current period, then low
      wait_rise(0);
      n = 1;
      wr(a_per(0), 32'd0);
      run_rest(0, n);
      chk("R8 pulse completes before stop", n, 15);
      count_high(0, 60, n); chk("R8 stopped output low", n, 0);
      rd(a_per(0), d); chk("R8 period reads zero when off", int'(d), 0);

      // R8: inverted channel also stops low (ch1)
      wr(a_ctl(1), 32'h20);
      wr(a_per(1), 32'd6);
      repeat (120) @(negedge clk);
      wr(a_per(1), 32'd0);
      repeat (120) @(negedge clk);
      count_high(1, 50, n); chk("R8 inverted channel stops low", n, 0);

      // R9: idle start on next tick (ch0, ratio 1)
      wr(a_dut(0), 32'd4);
      wr(a_per(0), 32'd8);
      chk("R9 still low right after write", int'(pwm_o[0]), 0);
      @(negedge clk);
      chk("R9 high on next tick", int'(pwm_o[0]), 1);
      n = 0;
      run_rest(0, n);
      chk("R9 first pulse length", n, 4);

      // R3: frozen timebase holds the level
      repeat (5) @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
      ref_lvl = pwm_o[0];
      n = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (pwm_o[0] != ref_lvl) n++;
      end
      chk("R3 no change without tick_en", n, 0);
      tick_en = 1'b1;
      repeat (20) @(negedge clk);
      count_high(0, 8, n); chk("R3 resumes after tick_en", n, 4);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule